// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the master-side transfer core of an SPI controller with four chip-select lines. It pulls 32-bit words from a transmit queue and shifts out bursts whose length in bits is programmable. Each word is sent as whole bytes, least significant byte first, and the bits of each byte go out MSB first in SPI mode 0. The bytes that come back on MISO are packed into a receive word in the same byte order and handed to a receive queue.

A burst begins in one of two ways. In immediate mode the engine drains the transmit queue whenever it holds data. In exchange mode software raises an exchange request, the engine sets its exchange flag, and the flag drops again when the burst bit count runs out. If the chip-select-control bit of the selected channel is set while in exchange mode, the engine chains bursts. It keeps draining the queue and raises the exchange flag again at the start of each new burst. Without that bit it stops at each burst end.

The transmit side is a valid/ready sink: a word is taken only in a cycle where both `tx_valid` and `tx_ready` are high. The receive side is a valid/ready source: `rx_valid` and `rx_data` hold steady until `rx_ready` is seen, and the engine fetches no further word in the meantime. Control and configuration inputs are plain levels, except `xch_req`, which is a one-cycle request pulse.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is `burst_field` + 1. A new length is loaded only when a word is fetched after the previous burst's remaining count has reached zero or gone below it. A burst may span several words.
- R2: Each fetched word sends ceil(min(remaining bits, 32) / 8) bytes. Byte 0 (bits 7:0) goes first, then bits 15:8, and so on. Each byte goes out MSB first on MOSI, with MOSI changing only while SCLK is low (SPI mode 0). Each byte lowers the remaining count by 8.
- R3: The received byte k of a word is placed at bits 8k+7:8k of `rx_data`. Byte positions that were not transferred read as zero.
- R4: The engine moves no data and takes no transmit word unless `en` is high and bit `chan_sel` of `chan_mode` is 1 (master).
- R5: One cycle after `en` is high with the selected channel in master mode, `cs_n[chan_sel]` is 0 and the other three are 1. Otherwise all four are 1.
- R6: With `start_mode` = 1, words are fetched and sent whenever the transmit queue is valid.
- R7: With `start_mode` = 0, an `xch_req` pulse sets `xch` and lets the engine fetch words. When a burst's count runs out, `xch` returns to 0 and `xch_done` pulses for one cycle.
- R8: When `start_mode` = 0 and bit `chan_sel` of `ss_ctl` is 1, the engine keeps fetching after a burst end while the queue is valid. It raises `xch` again for each new burst, giving one `xch_done` per burst.
- R9: Outside chained mode, the engine stops at each burst end and pulses `tc_pulse`. `tc_pulse` also pulses after any word whose completion leaves the transmit queue empty.
- R10: SCLK idles low. Each SCLK half-period lasts max(`clk_div`, 1) clock cycles.
- R11: `busy` goes high when a word is fetched and stays high until that word's receive value has been accepted. While `rx_ready` is low, `rx_valid` and `rx_data` hold.
- R12: `xch_req` is ignored while `start_mode` = 1 or while the selected channel is not master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low aborts and clears all transfer state |
| chan_sel | input | 2 | Selected channel |
| chan_mode | input | 4 | Per-channel master bit |
| ss_ctl | input | 4 | Per-channel chained-burst chip-select control |
| start_mode | input | 1 | 1 = immediate start, 0 = exchange-request start |
| xch_req | input | 1 | One-cycle request to set the exchange flag |
| burst_field | input | 8 | Burst length minus one, in bits |
| clk_div | input | 4 | SCLK half-period in clock cycles (0 acts as 1) |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receive queue accepts the word |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Word transfer in progress |
| xch | output | 1 | Exchange flag |
| tc_pulse | output | 1 | Transfer-complete pulse |
| xch_done | output | 1 | Exchange-done pulse at burst end |

## Verification
The bench builds the block with its defaults: a 32-bit word, an 8-bit burst field and a 4-bit divider. With these values, bursts of 12, 20, 40 and 64 bits all fit in a short run. That covers partial-word tails, bursts that cross a word boundary, and bursts that end exactly on a word edge. The 4-bit divider lets the bench run most transfers at the minimum divide of 2 and still measure a wider SCLK period. MISO is the inverse of MOSI, so every expected receive word follows directly from the transmitted bytes.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LOAD,
    ENG_SHIFT,
    ENG_PUSH,
    ENG_NEXT
  } eng_state_t;
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cycles,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  // a zero setting behaves as one cycle per half-period
  assign last = (half_cycles == '0) ? '0 : half_cycles - DIV_W'(1);
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       run,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  logic [7:0] sh_q;
  logic [7:0] rx_q;
  logic [2:0] bit_q;
  logic       run_q;
  logic       sclk_q;
  logic       done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rx_q <= '0; bit_q <= '0;
      run_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (kill) begin
        run_q  <= 1'b0;
        sclk_q <= 1'b0;
      end else if (start) begin
        sh_q   <= tx_byte;
        bit_q  <= '0;
        run_q  <= 1'b1;
        sclk_q <= 1'b0;
      end else if (run_q && tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign run     = run_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
  assign rx_byte = rx_q;
  assign done    = done_q;

  // R2: MOSI may only change while SCLK is low
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sh_q[7]));
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BL_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              chained,
  input  logic              start_mode,
  input  logic              xch_req,
  input  logic [BL_W-1:0]   burst_field,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sh_start,
  output logic [7:0]        sh_byte,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              busy,
  output logic              xch,
  output logic              tc_pulse,
  output logic              xch_done
);
  localparam int BYTES = DATA_W / 8;
  localparam int NBW   = $clog2(BYTES + 1);
  localparam int RW    = (BL_W + 2 > $clog2(DATA_W) + 2) ? BL_W + 2 : $clog2(DATA_W) + 2;
  localparam logic signed [RW-1:0] ZERO      = '0;
  localparam logic signed [RW-1:0] ONE       = RW'(1);
  localparam logic signed [RW-1:0] BYTE_BITS = RW'(8);
  localparam logic signed [RW-1:0] WORD_BITS = RW'(DATA_W);
  localparam logic [RW-1:0]        ROUND_UP  = RW'(7);

  eng_state_t st_q;
  logic signed [RW-1:0] rem_q, rem_eff, burst_bits, chunk;
  logic [RW-1:0]        chunk_rnd;
  logic [NBW-1:0]       nb_q, nb_calc, bidx_q;
  logic [DATA_W-1:0]    word_q, rxw_q;
  logic                 xch_q, chain_q, tc_q, xd_q, fire;

  assign burst_bits = $signed({{(RW-BL_W){1'b0}}, burst_field}) + ONE;
  assign rem_eff    = (rem_q <= ZERO) ? burst_bits : rem_q;
  assign chunk      = (rem_eff > WORD_BITS) ? WORD_BITS : rem_eff;
  assign chunk_rnd  = $unsigned(chunk) + ROUND_UP;
  assign nb_calc    = NBW'(chunk_rnd >> 3);

  assign fire = (st_q == ENG_IDLE) && en && master && tx_valid &&
                (start_mode || xch_q || chain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENG_IDLE; rem_q <= ZERO; nb_q <= '0; bidx_q <= '0;
      word_q <= '0; rxw_q <= '0; xch_q <= 1'b0; chain_q <= 1'b0;
      tc_q <= 1'b0; xd_q <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      xd_q <= 1'b0;
      if (!en) begin
        st_q <= ENG_IDLE; rem_q <= ZERO; xch_q <= 1'b0; chain_q <= 1'b0;
      end else begin
        if (xch_req && master && !start_mode) xch_q <= 1'b1;
        case (st_q)
          ENG_IDLE: if (fire) begin
            word_q  <= tx_data;
            rem_q   <= rem_eff;
            nb_q    <= nb_calc;
            bidx_q  <= '0;
            rxw_q   <= '0;
            chain_q <= 1'b0;
            if (rem_q <= ZERO && chained) xch_q <= 1'b1;
            st_q    <= ENG_LOAD;
          end
          ENG_LOAD: st_q <= ENG_SHIFT;
          ENG_SHIFT: if (sh_done) begin
            rxw_q[{bidx_q, 3'b000} +: 8] <= sh_rx;
            word_q <= word_q >> 8;
            rem_q  <= rem_q - BYTE_BITS;
            if (bidx_q == nb_q - NBW'(1)) st_q <= ENG_PUSH;
            else begin
              bidx_q <= bidx_q + NBW'(1);
              st_q   <= ENG_LOAD;
            end
          end
          ENG_PUSH: if (rx_ready) st_q <= ENG_NEXT;
          ENG_NEXT: begin
            st_q <= ENG_IDLE;
            if (rem_q <= ZERO) begin
              xch_q   <= 1'b0;
              xd_q    <= 1'b1;
              tc_q    <= !chained || !tx_valid;
              chain_q <= chained && tx_valid;
            end else begin
              tc_q <= !tx_valid;
            end
          end
          default: st_q <= ENG_IDLE;
        endcase
      end
    end
  end

  assign tx_ready = fire;
  assign rx_valid = (st_q == ENG_PUSH);
  assign rx_data  = rxw_q;
  assign sh_start = (st_q == ENG_LOAD);
  assign sh_byte  = word_q[7:0];
  assign busy     = (st_q != ENG_IDLE);
  assign xch      = xch_q;
  assign tc_pulse = tc_q;
  assign xch_done = xd_q;

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && en) |=> (!en || (rx_valid && $stable(rx_data))));
  // R7
  xch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xch_done |-> !xch);
  // R4
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (master && en));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int DATA_W = 32,
  parameter int BL_W   = 8,
  parameter int DIV_W  = 4,
  parameter int NCS    = 4,
  localparam int CSW   = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CSW-1:0]    chan_sel,
  input  logic [NCS-1:0]    chan_mode,
  input  logic [NCS-1:0]    ss_ctl,
  input  logic              start_mode,
  input  logic              xch_req,
  input  logic [BL_W-1:0]   burst_field,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    cs_n,
  output logic              busy,
  output logic              xch,
  output logic              tc_pulse,
  output logic              xch_done
);
  logic master, chained;
  logic sh_start, sh_done, sh_run, tick;
  logic [7:0] sh_byte, sh_rx;
  logic [NCS-1:0] cs_q;

  assign master  = chan_mode[chan_sel];
  assign chained = master && !start_mode && ss_ctl[chan_sel];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q[g] <= 1'b1;
      else        cs_q[g] <= !(en && master && (chan_sel == CSW'(g)));
    end
  end
  assign cs_n = cs_q;

  spi_burst_ctrl #(.DATA_W(DATA_W), .BL_W(BL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .chained(chained),
    .start_mode(start_mode), .xch_req(xch_req), .burst_field(burst_field),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(busy), .xch(xch), .tc_pulse(tc_pulse), .xch_done(xch_done)
  );

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(sh_run), .half_cycles(clk_div), .tick(tick)
  );

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .kill(!en), .start(sh_start), .tx_byte(sh_byte),
    .tick(tick), .miso(miso), .run(sh_run), .sclk(sclk), .mosi(mosi),
    .rx_byte(sh_rx), .done(sh_done)
  );

  // R5
  cs_onecold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master) |=> ($countones(~cs_n) == 1));
  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
endmodule

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        en = 0, start_mode = 0, xch_req = 0, rx_ready = 1;
  logic [1:0]  chan_sel = 0;
  logic [3:0]  chan_mode = 0, ss_ctl = 0, clk_div = 1;
  logic [7:0]  burst_field = 0;
  logic [31:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, miso, sclk, mosi, busy, xch, tc_pulse, xch_done;
  logic [3:0]  cs_n;

  int tests = 0, fails = 0;

  // transmit queue model
  logic [31:0] txq [64];
  int tx_wr = 0, tx_rd = 0;
  assign tx_valid = (tx_wr != tx_rd);
  assign tx_data  = txq[tx_rd % 64];
  always @(posedge clk) if (tx_valid && tx_ready) tx_rd <= tx_rd + 1;

  // receive log
  logic [31:0] rxl [64];
  int rx_n = 0;
  always @(posedge clk) if (rx_valid && rx_ready) begin rxl[rx_n % 64] <= rx_data; rx_n <= rx_n + 1; end

  // pulse counters
  int tc_n = 0, xd_n = 0;
  always @(posedge clk) begin
    if (tc_pulse) tc_n <= tc_n + 1;
    if (xch_done) xd_n <= xd_n + 1;
  end

  // serial monitor; slave returns inverted MOSI
  assign miso = ~mosi;
  logic [7:0] mb [64];
  int mb_n = 0, bitc = 0;
  logic [7:0] msh = 0;
  time last_rise = 0, rise_gap = 0;
  always @(posedge sclk) begin
    if (bitc != 0) rise_gap = $time - last_rise;
    last_rise = $time;
    msh = {msh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin mb[mb_n % 64] = msh; mb_n++; bitc = 0; end
  end

  spi_burst_engine u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .chan_sel(chan_sel), .chan_mode(chan_mode),
    .ss_ctl(ss_ctl), .start_mode(start_mode), .xch_req(xch_req), .burst_field(burst_field),
    .clk_div(clk_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .xch(xch),
    .tc_pulse(tc_pulse), .xch_done(xch_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] got, input logic [31:0] exp);
    chk(got === exp, req, got, exp);
  endtask

  task automatic push(input logic [31:0] w);
    txq[tx_wr % 64] = w;
    tx_wr = tx_wr + 1;
  endtask

  task automatic setup(input logic sm, input logic [3:0] ss, input logic [7:0] bf, input logic [3:0] dv);
    @(negedge clk);
    en = 0; xch_req = 0; rx_ready = 1;
    repeat (2) @(negedge clk);
    tx_rd = tx_wr;
    chan_sel = 2'd1; chan_mode = 4'b0010;
    start_mode = sm; ss_ctl = ss; burst_field = bf; clk_div = dv;
    en = 1;
    @(negedge clk);
  endtask

  task automatic pulse_xch();
    @(negedge clk); xch_req = 1;
    @(negedge clk); xch_req = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] inv_pack(input logic [31:0] w, input int nbytes);
    logic [31:0] r = 0;
    for (int k = 0; k < nbytes; k++) r[8*k +: 8] = ~w[8*k +: 8];
    return r;
  endfunction

  task automatic t_reset();
    eq("R5 reset cs_n", {28'h0, cs_n}, 32'hF);
    eq("R10 reset sclk", {31'h0, sclk}, 0);
    eq("R11 reset busy", {31'h0, busy}, 0);
  endtask

  task automatic t_cs();
    setup(1, 0, 8'd31, 1);
    eq("R5 cs select ch1", {28'h0, cs_n}, 32'hD);
    @(negedge clk); chan_mode = 4'b0000;
    @(negedge clk);
    eq("R5 cs not master", {28'h0, cs_n}, 32'hF);
  endtask

  task automatic t_immediate();
    int m0, r0, t0;
    setup(1, 0, 8'd31, 1);
    m0 = mb_n; r0 = rx_n; t0 = tc_n;
    push(32'h04030201); push(32'hA1B2C3D4);
    settle(400);
    eq("R6 bytes sent", mb_n - m0, 8);
    eq("R2 byte0 lsb first", {24'h0, mb[m0 % 64]}, 32'h01);
    eq("R2 byte3", {24'h0, mb[(m0+3) % 64]}, 32'h04);
    eq("R2 word2 byte0", {24'h0, mb[(m0+4) % 64]}, 32'hD4);
    eq("R3 rx word0", rxl[r0 % 64], 32'hFBFCFDFE);
    eq("R3 rx word1", rxl[(r0+1) % 64], inv_pack(32'hA1B2C3D4, 4));
    eq("R9 tc per burst", tc_n - t0, 2);
  endtask

  task automatic t_short_burst();
    int m0, r0;
    setup(1, 0, 8'd11, 1);
    m0 = mb_n; r0 = rx_n;
    push(32'hAABBCCDD); push(32'h12345678);
    settle(300);
    eq("R1 12-bit bursts byte count", mb_n - m0, 4);
    eq("R2 second byte", {24'h0, mb[(m0+1) % 64]}, 32'hCC);
    eq("R3 rx partial word", rxl[r0 % 64], 32'h00003322);
    eq("R1 reload second burst", rxl[(r0+1) % 64], 32'h0000A987);
  endtask

  task automatic t_span_burst();
    int m0, r0;
    setup(1, 0, 8'd39, 1);
    m0 = mb_n; r0 = rx_n;
    push(32'h11223344); push(32'h55667788);
    settle(400);
    eq("R1 40-bit burst spans words", mb_n - m0, 5);
    eq("R2 tail byte", {24'h0, mb[(m0+4) % 64]}, 32'h88);
    eq("R3 tail rx word", rxl[(r0+1) % 64], 32'h00000077);
  endtask

  task automatic t_20bit();
    int r0;
    setup(1, 0, 8'd19, 1);
    r0 = rx_n;
    push(32'h11223344);
    settle(250);
    eq("R3 20-bit rx", rxl[r0 % 64], 32'h00DDCCBB);
  endtask

  task automatic t_exchange();
    int m0, r0, t0, x0;
    setup(0, 4'b0000, 8'd63, 1);
    m0 = mb_n; r0 = rx_n; t0 = tc_n; x0 = xd_n;
    push(32'h0); push(32'h1); push(32'h2);
    settle(100);
    eq("R7 waits for xch_req", mb_n - m0, 0);
    pulse_xch();
    settle(600);
    eq("R7 one 64-bit burst", rx_n - r0, 2);
    eq("R7 xch cleared", {31'h0, xch}, 0);
    eq("R7 xch_done once", xd_n - x0, 1);
    eq("R9 stop leaves word", tx_wr - tx_rd, 1);
    eq("R9 tc at burst end", tc_n - t0, 1);
  endtask

  task automatic t_chained();
    int r0, t0, x0;
    setup(0, 4'b0010, 8'd31, 1);
    r0 = rx_n; t0 = tc_n; x0 = xd_n;
    push(32'hCAFE0001); push(32'hCAFE0002); push(32'hCAFE0003);
    pulse_xch();
    settle(800);
    eq("R8 all words drained", rx_n - r0, 3);
    eq("R8 xch_done per burst", xd_n - x0, 3);
    eq("R9 tc when queue empties", tc_n - t0, 1);
    eq("R8 last rx", rxl[(r0+2) % 64], inv_pack(32'hCAFE0003, 4));
  endtask

  task automatic t_not_master();
    int m0;
    setup(1, 0, 8'd7, 1);
    @(negedge clk); chan_mode = 4'b1101;
    m0 = mb_n;
    push(32'h5A);
    settle(150);
    eq("R4 nothing sent", mb_n - m0, 0);
    eq("R4 word not taken", tx_wr - tx_rd, 1);
    eq("R4 not busy", {31'h0, busy}, 0);
  endtask

  task automatic t_xch_ignored();
    setup(1, 0, 8'd7, 1);
    pulse_xch();
    @(negedge clk);
    eq("R12 xch_req ignored in start mode", {31'h0, xch}, 0);
    setup(0, 0, 8'd7, 1);
    @(negedge clk); chan_mode = 4'b0000;
    pulse_xch();
    @(negedge clk); chan_mode = 4'b0010;
    @(negedge clk);
    eq("R12 xch_req ignored when not master", {31'h0, xch}, 0);
  endtask

  task automatic t_div();
    setup(1, 0, 8'd7, 3);
    push(32'h96);
    settle(150);
    eq("R10 sclk period at div 3", 32'(rise_gap), 32'd24);
    eq("R10 sclk idle", {31'h0, sclk}, 0);
  endtask

  task automatic t_backpressure();
    int r0;
    setup(1, 0, 8'd7, 1);
    rx_ready = 0;
    r0 = rx_n;
    push(32'h5A);
    settle(150);
    eq("R11 busy held", {31'h0, busy}, 1);
    eq("R11 rx_valid held", {31'h0, rx_valid}, 1);
    eq("R11 rx_data held", rx_data, 32'hA5);
    rx_ready = 1;
    settle(4);
    eq("R11 busy released", {31'h0, busy}, 0);
    eq("R11 accepted once", rx_n - r0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cs();
    t_immediate();
    t_short_burst();
    t_span_burst();
    t_20bit();
    t_exchange();
    t_chained();
    t_not_master();
    t_xch_ignored();
    t_div();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule